// File: doc/BRIEF.md
# Single-cycle load/store integer core

A compact 32-bit processor that completes one instruction per clock. It runs a small integer subset: register add and subtract, add with a signed constant, word load, word store, two compare-and-branch forms and an absolute jump. Every instruction uses one of three fixed 32-bit layouts. The core holds thirty-one writable 32-bit general registers, a register 0 that always reads zero, and a program counter.

Program and data live in two small word-organised memories inside the block. A side write port fills them, normally while the core is held in reset. Debug read ports show any general register, any data-memory word and the current PC. A sticky error flag stops the core when it meets a misaligned memory access or an encoding it does not know.

Top module: `lsr_core`

## Requirements
- R1: While rst_ni is low, pc_o reads 0, err_o reads 0 and every general register reads 0.
- R2: Opcode 0 (bits [31:26]) with function code 32 (bits [5:0]) writes rs+rt into rd, and with function code 34 writes rs-rt into rd. Fields: rs [25:21], rt [20:16], rd [15:11]. Results wrap modulo 2^32.
- R3: Opcode 8 writes rs plus the sign-extended 16-bit field [15:0] into rt.
- R4: Register 0 always reads zero, and a write aimed at it changes nothing.
- R5: Opcode 35 loads and opcode 43 stores a word. The byte address is rs plus the sign-extended offset [15:0], and rt is the data register. The data word index is the byte address divided by 4. A store is visible from the edge that executes it.
- R6: Opcode 4 branches when rs equals rt, and opcode 5 branches when they differ. A taken branch goes to PC+4 plus the sign-extended offset times 4. A branch that is not taken goes to PC+4.
- R7: Opcode 2 always jumps. The target is bits [31:28] of PC+4, then the 26-bit field [25:0], then two zero bits.
- R8: A load or store whose byte address has nonzero bits [1:0] sets err_o from the next edge on. After that no register or data-memory write happens, and the PC stays where it is until reset.
- R9: An unknown opcode, or opcode 0 with a function code other than 32 or 34, has the same effect as R8.
- R10: Any instruction that is not a branch or a jump, and that does not fault, moves the PC to PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prog_we_i | input | 1 | Side-port write strobe for the memories |
| prog_dmem_i | input | 1 | Side-port target: 1 data memory, 0 instruction memory |
| prog_addr_i | input | PROG_AW | Side-port word index |
| prog_data_i | input | 32 | Side-port write data |
| dbg_reg_addr_i | input | 5 | Register number to observe |
| dbg_reg_data_o | output | 32 | Value of the observed register |
| dbg_mem_addr_i | input | DMEM_AW | Data-memory word index to observe |
| dbg_mem_data_o | output | 32 | Value of the observed data word |
| pc_o | output | 32 | Current program counter |
| err_o | output | 1 | Sticky fault flag |

## Verification
The assertions check four things on every cycle: the fault flag stays set once it is set, the PC stays frozen after a fault, an unknown encoding raises the flag, and sequential instructions advance the PC by four. Arithmetic results, zero-register protection, address formation, branch and jump targets, and the absence of writes after a fault can only be seen by running programs. The bench runs several short programs against an instruction-level model and compares the PC, the flag and a rotating register every cycle. It then compares all registers and the data words once each program ends.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RAW  = $clog2(NREG);

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_JMP   = 6'd2;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_BNE   = 6'd5;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_LW    = 6'd35;
  localparam logic [5:0] OP_SW    = 6'd43;
  localparam logic [5:0] FN_ADD   = 6'd32;
  localparam logic [5:0] FN_SUB   = 6'd34;

  typedef struct packed {
    logic reg_we;
    logic dst_rd;
    logic use_imm;
    logic alu_sub;
    logic mem_rd;
    logic mem_wr;
    logic br_eq;
    logic br_ne;
    logic jump;
    logic illegal;
  } ctl_t;
endpackage

// File: rtl/lsr_decode.sv
module lsr_decode
  import lsr_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] fn_i,
  output ctl_t       ctl_o
);
  always_comb begin
    ctl_o = '0;
    case (op_i)
      OP_RTYPE: begin
        case (fn_i)
          FN_ADD: begin ctl_o.reg_we = 1'b1; ctl_o.dst_rd = 1'b1; end
          FN_SUB: begin ctl_o.reg_we = 1'b1; ctl_o.dst_rd = 1'b1; ctl_o.alu_sub = 1'b1; end
          default: ctl_o.illegal = 1'b1;
        endcase
      end
      OP_ADDI: begin ctl_o.reg_we = 1'b1; ctl_o.use_imm = 1'b1; end
      OP_LW:   begin ctl_o.reg_we = 1'b1; ctl_o.use_imm = 1'b1; ctl_o.mem_rd = 1'b1; end
      OP_SW:   begin ctl_o.use_imm = 1'b1; ctl_o.mem_wr = 1'b1; end
      OP_BEQ:  ctl_o.br_eq = 1'b1;
      OP_BNE:  ctl_o.br_ne = 1'b1;
      OP_JMP:  ctl_o.jump = 1'b1;
      default: ctl_o.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsr_regfile.sv
module lsr_regfile #(
  parameter int NREG = 32,
  parameter int XLEN = 32,
  parameter int NRD  = 3,
  localparam int RAW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [RAW-1:0]  waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [RAW-1:0]  raddr_i [NRD],
  output logic [XLEN-1:0] rdata_o [NRD]
);
  logic [XLEN-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs_q[g] = '0;
    end else begin : g_flop
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        regs_q[g] <= '0;
        else if (we_i && waddr_i == RAW'(g)) regs_q[g] <= wdata_i;
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = regs_q[raddr_i[p]];
  end
endmodule

// File: rtl/lsr_ram.sv
module lsr_ram #(
  parameter int AW  = 6,
  parameter int DW  = 32,
  parameter int NRD = 1,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i [NRD],
  output logic [DW-1:0] rdata_o [NRD]
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = mem_q[raddr_i[p]];
  end
endmodule

// File: rtl/lsr_core.sv
module lsr_core
  import lsr_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  parameter int PROG_AW = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               prog_we_i,
  input  logic               prog_dmem_i,
  input  logic [PROG_AW-1:0] prog_addr_i,
  input  logic [31:0]        prog_data_i,
  input  logic [4:0]         dbg_reg_addr_i,
  output logic [31:0]        dbg_reg_data_o,
  input  logic [DMEM_AW-1:0] dbg_mem_addr_i,
  output logic [31:0]        dbg_mem_data_o,
  output logic [31:0]        pc_o,
  output logic               err_o
);
  logic [XLEN-1:0] pc_q, pc_d;
  logic            err_q;

  // instruction memory
  logic [IMEM_AW-1:0] im_raddr [1];
  logic [31:0]        im_rdata [1];
  logic [31:0]        instr;

  assign im_raddr[0] = pc_q[IMEM_AW+1:2];
  assign instr       = im_rdata[0];

  lsr_ram #(.AW(IMEM_AW), .DW(32), .NRD(1)) u_imem (
    .clk_i   (clk_i),
    .we_i    (prog_we_i && !prog_dmem_i),
    .waddr_i (prog_addr_i[IMEM_AW-1:0]),
    .wdata_i (prog_data_i),
    .raddr_i (im_raddr),
    .rdata_o (im_rdata)
  );

  // fields
  logic [5:0]      f_op, f_fn;
  logic [RAW-1:0]  f_rs, f_rt, f_rd;
  logic [XLEN-1:0] imm_sx;

  assign f_op   = instr[31:26];
  assign f_rs   = instr[25:21];
  assign f_rt   = instr[20:16];
  assign f_rd   = instr[15:11];
  assign f_fn   = instr[5:0];
  assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};

  ctl_t ctl;
  lsr_decode u_dec (.op_i(f_op), .fn_i(f_fn), .ctl_o(ctl));

  // register file: rs, rt, debug
  logic [RAW-1:0]  rf_raddr [3];
  logic [XLEN-1:0] rf_rdata [3];
  logic            rf_we;
  logic [RAW-1:0]  rf_waddr;
  logic [XLEN-1:0] rf_wdata, rs_val, rt_val;

  assign rf_raddr[0] = f_rs;
  assign rf_raddr[1] = f_rt;
  assign rf_raddr[2] = dbg_reg_addr_i;
  assign rs_val      = rf_rdata[0];
  assign rt_val      = rf_rdata[1];

  lsr_regfile #(.NREG(NREG), .XLEN(XLEN), .NRD(3)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we),
    .waddr_i (rf_waddr),
    .wdata_i (rf_wdata),
    .raddr_i (rf_raddr),
    .rdata_o (rf_rdata)
  );

  // datapath
  logic [XLEN-1:0] alu_b, alu_res;
  logic            misalign, fault, commit;

  assign alu_b    = ctl.use_imm ? imm_sx : rt_val;
  assign alu_res  = ctl.alu_sub ? (rs_val - alu_b) : (rs_val + alu_b);
  assign misalign = (ctl.mem_rd || ctl.mem_wr) && (alu_res[1:0] != 2'b00);
  assign fault    = ctl.illegal || misalign;
  assign commit   = !err_q && !fault;

  // data memory: core, debug
  logic [DMEM_AW-1:0] dm_raddr [2];
  logic [31:0]        dm_rdata [2];
  logic               dm_prog, dm_we;
  logic [DMEM_AW-1:0] dm_waddr;
  logic [31:0]        dm_wdata;

  assign dm_prog     = prog_we_i && prog_dmem_i;
  assign dm_raddr[0] = alu_res[DMEM_AW+1:2];
  assign dm_raddr[1] = dbg_mem_addr_i;
  assign dm_we       = dm_prog || (ctl.mem_wr && commit);
  assign dm_waddr    = dm_prog ? prog_addr_i[DMEM_AW-1:0] : alu_res[DMEM_AW+1:2];
  assign dm_wdata    = dm_prog ? prog_data_i : rt_val;

  lsr_ram #(.AW(DMEM_AW), .DW(32), .NRD(2)) u_dmem (
    .clk_i   (clk_i),
    .we_i    (dm_we),
    .waddr_i (dm_waddr),
    .wdata_i (dm_wdata),
    .raddr_i (dm_raddr),
    .rdata_o (dm_rdata)
  );

  assign rf_we    = ctl.reg_we && commit;
  assign rf_waddr = ctl.dst_rd ? f_rd : f_rt;
  assign rf_wdata = ctl.mem_rd ? dm_rdata[0] : alu_res;

  // next pc
  logic [XLEN-1:0] pc_inc, br_tgt, jmp_tgt;
  logic            br_take;

  assign pc_inc  = pc_q + XLEN'(4);
  assign br_tgt  = pc_inc + {imm_sx[XLEN-3:0], 2'b00};
  assign jmp_tgt = {pc_inc[XLEN-1:28], instr[25:0], 2'b00};
  assign br_take = (ctl.br_eq && (rs_val == rt_val)) || (ctl.br_ne && (rs_val != rt_val));

  always_comb begin
    if (err_q || fault) pc_d = pc_q;
    else if (ctl.jump)  pc_d = jmp_tgt;
    else if (br_take)   pc_d = br_tgt;
    else                pc_d = pc_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      err_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      err_q <= err_q || fault;
    end
  end

  assign pc_o           = pc_q;
  assign err_o          = err_q;
  assign dbg_reg_data_o = rf_rdata[2];
  assign dbg_mem_data_o = dm_rdata[1];

  logic unused_bits;
  assign unused_bits = ^{instr[10:6], pc_q[1:0], alu_res, prog_addr_i};

  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);

  // R8
  pc_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> $stable(pc_q));

  // R9
  illegal_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_q && ctl.illegal) |=> err_q);

  // R10
  seq_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_q && !fault && !ctl.jump && !ctl.br_eq && !ctl.br_ne)
      |=> (pc_q == $past(pc_q) + 32'd4));
endmodule

// File: tb/lsr_core_tb.sv
module lsr_core_tb;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          prog_we_i = 1'b0;
  logic          prog_dmem_i = 1'b0;
  logic [AW-1:0] prog_addr_i = '0;
  logic [31:0]   prog_data_i = '0;
  logic [4:0]    dbg_reg_addr_i = '0;
  logic [31:0]   dbg_reg_data_o;
  logic [AW-1:0] dbg_mem_addr_i = '0;
  logic [31:0]   dbg_mem_data_o;
  logic [31:0]   pc_o;
  logic          err_o;

  always #4 clk_i = ~clk_i;

  lsr_core u_dut (
    .clk_i, .rst_ni, .prog_we_i, .prog_dmem_i, .prog_addr_i, .prog_data_i,
    .dbg_reg_addr_i, .dbg_reg_data_o, .dbg_mem_addr_i, .dbg_mem_data_o,
    .pc_o, .err_o
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] prog  [DEPTH];
  logic [31:0] dinit [DEPTH];
  logic [31:0] m_imem [DEPTH];
  logic [31:0] m_dmem [DEPTH];
  logic [31:0] m_reg [32];
  logic [31:0] m_pc;
  logic        m_err;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] e_r(int rs, int rt, int rd, int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction
  function automatic logic [31:0] e_i(int op, int rs, int rt, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] e_j(int word);
    return {6'd2, word[25:0]};
  endfunction

  // instruction-level reference
  task automatic m_step();
    logic [31:0] ins, a, b, sx, npc, ea, res;
    logic [5:0]  op, fn;
    int          wr;
    bit          flt;
    if (m_err) return;
    ins = m_imem[m_pc[AW+1:2]];
    op = ins[31:26]; fn = ins[5:0];
    a = m_reg[ins[25:21]]; b = m_reg[ins[20:16]];
    sx = {{16{ins[15]}}, ins[15:0]};
    npc = m_pc + 4; wr = -1; res = 0; flt = 0;
    case (op)
      6'd0: begin
        if (fn == 6'd32) begin res = a + b; wr = ins[15:11]; end
        else if (fn == 6'd34) begin res = a - b; wr = ins[15:11]; end
        else flt = 1;
      end
      6'd8: begin res = a + sx; wr = ins[20:16]; end
      6'd35: begin
        ea = a + sx;
        if (ea[1:0] != 0) flt = 1;
        else begin res = m_dmem[ea[AW+1:2]]; wr = ins[20:16]; end
      end
      6'd43: begin
        ea = a + sx;
        if (ea[1:0] != 0) flt = 1;
        else m_dmem[ea[AW+1:2]] = b;
      end
      6'd4: if (a == b) npc = npc + (sx << 2);
      6'd5: if (a != b) npc = npc + (sx << 2);
      6'd2: npc = {npc[31:28], ins[25:0], 2'b00};
      default: flt = 1;
    endcase
    if (flt) m_err = 1;
    else begin
      if (wr > 0) m_reg[wr] = res;
      m_pc = npc;
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < DEPTH; i++) begin prog[i] = 32'h0; dinit[i] = 32'h0; end
  endtask

  task automatic start(input string name);
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk_i);
      prog_we_i = 1'b1; prog_dmem_i = 1'b0; prog_addr_i = AW'(i); prog_data_i = prog[i];
      @(negedge clk_i);
      prog_dmem_i = 1'b1; prog_data_i = dinit[i];
    end
    @(negedge clk_i);
    prog_we_i = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin m_imem[i] = prog[i]; m_dmem[i] = dinit[i]; end
    for (int i = 0; i < 32; i++) m_reg[i] = 32'h0;
    m_pc = 0; m_err = 0;
    dbg_reg_addr_i = 5'd1;
    #1;
    chk(pc_o == 0, {"R1 pc ", name}, pc_o, 0);
    chk(err_o == 0, {"R1 err ", name}, {31'd0, err_o}, 0);
    chk(dbg_reg_data_o == 0, {"R1 reg ", name}, dbg_reg_data_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic run(input int n, input string name);
    for (int k = 0; k < n; k++) begin
      @(posedge clk_i);
      m_step();
      @(negedge clk_i);
      dbg_reg_addr_i = 5'(k);
      #1;
      chk(pc_o == m_pc, {"R6 R7 R10 pc ", name}, pc_o, m_pc);
      chk(err_o == m_err, {"R8 R9 err ", name}, {31'd0, err_o}, {31'd0, m_err});
      chk(dbg_reg_data_o == m_reg[k % 32], {"R2 R3 R4 R5 reg ", name}, dbg_reg_data_o, m_reg[k % 32]);
    end
    for (int r = 0; r < 32; r++) begin
      dbg_reg_addr_i = 5'(r);
      #1;
      chk(dbg_reg_data_o == m_reg[r], {"R2 R3 R4 R5 final reg ", name}, dbg_reg_data_o, m_reg[r]);
    end
    for (int w = 0; w < 8; w++) begin
      dbg_mem_addr_i = AW'(w);
      #1;
      chk(dbg_mem_data_o == m_dmem[w], {"R5 R8 final mem ", name}, dbg_mem_data_o, m_dmem[w]);
    end
  endtask

  initial begin
    // main program: arithmetic, r0, memory, branches, jump
    clear_prog();
    prog[0]  = e_i(8, 0, 1, 5);
    prog[1]  = e_i(8, 0, 2, -3);
    prog[2]  = e_r(1, 2, 3, 32);
    prog[3]  = e_r(1, 2, 4, 34);
    prog[4]  = e_i(8, 1, 0, 7);      // R4 write to r0
    prog[5]  = e_i(43, 0, 4, 8);
    prog[6]  = e_i(35, 0, 5, 8);
    prog[7]  = e_i(8, 0, 6, 12);
    prog[8]  = e_i(35, 6, 7, -4);    // R5 negative offset
    prog[9]  = e_i(4, 5, 4, 1);      // R6 beq taken
    prog[10] = e_i(8, 0, 8, 99);
    prog[11] = e_i(5, 1, 1, 1);      // R6 bne not taken
    prog[12] = e_i(8, 0, 9, 1);
    prog[13] = e_i(5, 1, 2, 1);      // R6 bne taken
    prog[14] = e_i(8, 0, 8, 77);
    prog[15] = e_j(17);              // R7
    prog[16] = e_i(8, 0, 8, 55);
    prog[17] = e_i(43, 6, 3, 0);
    prog[18] = e_i(8, 12, 12, 1);
    prog[19] = e_i(8, 0, 13, 3);
    prog[20] = e_i(5, 12, 13, -3);   // R6 backward loop
    prog[21] = e_i(35, 0, 14, 20);
    prog[22] = e_r(3, 4, 10, 32);
    prog[23] = e_r(0, 1, 15, 34);    // R2 wrap to negative
    prog[24] = e_r(0, 15, 15, 34);
    prog[25] = e_j(25);
    dinit[5] = 32'h1234_5678;
    start("main");
    run(70, "main");

    // R8 misaligned load
    clear_prog();
    prog[0] = e_i(8, 0, 1, 6);
    prog[1] = e_i(35, 1, 2, 0);
    prog[2] = e_i(8, 0, 3, 9);
    prog[3] = e_j(3);
    dinit[1] = 32'hCAFE_0001;
    start("misaligned load");
    run(12, "misaligned load");

    // R8 misaligned store
    clear_prog();
    prog[0] = e_i(8, 0, 1, 2);
    prog[1] = e_i(43, 0, 1, 1);
    prog[2] = e_i(43, 0, 1, 0);
    prog[3] = e_j(3);
    dinit[0] = 32'hAAAA_5555;
    start("misaligned store");
    run(12, "misaligned store");

    // R9 unknown function code
    clear_prog();
    prog[0] = e_i(8, 0, 1, 4);
    prog[1] = e_r(1, 1, 2, 37);
    prog[2] = e_i(8, 0, 3, 1);
    prog[3] = e_j(3);
    start("bad funct");
    run(10, "bad funct");

    // R9 unknown opcode
    clear_prog();
    prog[0] = e_i(8, 0, 1, 4);
    prog[1] = e_i(63, 1, 2, 0);
    prog[2] = e_i(43, 0, 1, 0);
    prog[3] = e_j(3);
    start("bad op");
    run(10, "bad op");

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=%h exp=%h", pc_o, 32'h0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule